// File: doc/BRIEF.md
# Reference-Clock Supervisor with Sticky Fallback Selection

This block watches an external oscillator input from a free-running internal reference clock. The external clock is treated as data: two flip-flops in the reference domain synchronise it, and a third stage detects edges. A quiet-time counter measures how long the synchronised signal has gone without a transition. If it stays quiet for too long while supervision is enabled, the block decides that the oscillator has stopped. It then selects the internal fallback frequency as the CPU clock source and raises an interrupt request flag.

The selection is synchronous: `sel_fallback` is a registered select for a downstream clock multiplexer. A prescaler strap is sampled once after each hardware reset. When that strap selects prescaler mode and the fallback is in use, `fb_div2_en` asks downstream logic to halve the fallback frequency. In direct-drive mode the fallback frequency is used undivided.

Once the fallback has been chosen, the choice holds even if the oscillator starts toggling again. Only the hardware reset returns the block to the external clock. Supervision can be switched off in two ways: by a low level on the enable pin (which a board pull-up normally holds high), or by a software disable bit. The pin and the bit are both sampled synchronously to the reference clock.

Top module: `osc_supervisor`

## Requirements
- R1: The external clock passes through two synchronising flops and one edge-detect flop. When monitoring is active and no synchronised edge has been seen for TIMEOUT (default 16) consecutive reference cycles, `sel_fallback` goes to 1 on the clock edge that ends the TIMEOUT-th quiet cycle.
- R2: An external clock whose synchronised edges are at most TIMEOUT cycles apart never causes a switchover. For example, edges 16 cycles apart never switch; edges 17 cycles apart do.
- R3: `fail_irq` goes to 1 in the same cycle that `sel_fallback` first goes to 1.
- R4: Once `sel_fallback` is 1, it stays 1 whatever the external clock, enable pin or software bit do. Only `rst_n` low clears it.
- R5: While `mon_en_pin` is 0, no switchover occurs and the quiet count restarts from zero.
- R6: While `sw_disable` is 1, no switchover occurs and the quiet count restarts from zero.
- R7: `fb_div2_en` is 1 exactly when `sel_fallback` is 1 and `prescale_mode` read 1 on the first clock edge after reset. Later changes of `prescale_mode` have no effect.
- R8: `fail_irq` is cleared on the clock edge at which `flag_clr` is 1. It is never cleared by the external clock resuming.
- R9: If `flag_clr` is 1 in the cycle a failure is detected, the set wins and `fail_irq` becomes 1.
- R10: While `rst_n` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running internal reference clock |
| rst_n | input | 1 | Hardware reset, asynchronous assert, active low |
| ext_clk_in | input | 1 | External oscillator signal being supervised |
| mon_en_pin | input | 1 | Supervision enable pin; low disables |
| sw_disable | input | 1 | Software disable bit; high disables |
| prescale_mode | input | 1 | Clock option strap, 1 = prescaler mode, sampled after reset |
| flag_clr | input | 1 | Software clear of the failure flag |
| sel_fallback | output | 1 | 1 = CPU clock taken from the fallback source |
| fb_div2_en | output | 1 | 1 = halve the fallback frequency |
| fail_irq | output | 1 | Sticky clock-failure interrupt request |

## Verification
Two functions can land on the same edge: a failure being detected, and software clearing the interrupt flag. The bench provokes this by holding `flag_clr` high throughout a stalled-clock interval. The detection edge therefore meets an active clear. The requirement is that `fail_irq` reads 1 for exactly that one cycle and then drops. A behavioural model is checked against the block on every cycle. The model counts quiet cycles from a queue of sampled input values. The bench also sweeps the edge spacing on both sides of the timeout and checks switchover latency with each disable held and released.

// File: rtl/osc_supervisor.sv
module osc_supervisor #(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ext_clk_in,
  input  logic mon_en_pin,
  input  logic sw_disable,
  input  logic prescale_mode,
  input  logic flag_clr,
  output logic sel_fallback,
  output logic fb_div2_en,
  output logic fail_irq
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        idle_cnt;
  logic                 strap_taken, mode_q;
  logic                 seen_edge, mon_active, timeout_hit;

  assign seen_edge   = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign mon_active  = mon_en_pin & ~sw_disable;
  assign timeout_hit = mon_active & ~seen_edge & ~sel_fallback &
                       (idle_cnt == CW'(TIMEOUT - 1));
  assign fb_div2_en  = sel_fallback & mode_q;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_in};

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n)
      idle_cnt <= '0;
    else if (!mon_active || seen_edge || sel_fallback || timeout_hit)
      idle_cnt <= '0;
    else
      idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      sel_fallback <= 1'b0;
      fail_irq     <= 1'b0;
    end else begin
      sel_fallback <= sel_fallback | timeout_hit;
      fail_irq     <= timeout_hit | (fail_irq & ~flag_clr);
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      strap_taken <= 1'b0;
      mode_q      <= 1'b0;
    end else if (!strap_taken) begin
      strap_taken <= 1'b1;
      mode_q      <= prescale_mode;
    end

  a_r1_count_bound: assert property (@(posedge clk_ref) disable iff (!rst_n)
    idle_cnt < CW'(TIMEOUT));
  a_r4_fallback_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sel_fallback |=> sel_fallback);
  a_r3_flag_with_switch: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(sel_fallback) |-> fail_irq);
  a_r5_pin_blocks: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!mon_en_pin && !sel_fallback) |=> !sel_fallback);
  a_r6_bit_blocks: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sw_disable && !sel_fallback) |=> !sel_fallback);
  a_r7_div_needs_fallback: assert property (@(posedge clk_ref) disable iff (!rst_n)
    fb_div2_en |-> sel_fallback);
  a_r8_clear_works: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (flag_clr && sel_fallback) |=> !fail_irq);
endmodule

// File: tb/sim_osc_supervisor.sv
module sim_osc_supervisor;
  localparam int T = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext = 1'b0, pin = 1'b1, swd = 1'b0, pre = 1'b0, clr = 1'b0;
  logic sel, div, irq;
  int total = 0, bad = 0, cyc = 0;
  string phase = "R10";
  bit done = 0;

  // model state
  bit q[$];
  int quiet = 0;
  bit m_sel = 0, m_irq = 0, m_mode = 0, m_strap = 0;

  always #4 clk = ~clk;

  osc_supervisor #(.TIMEOUT(T), .SYNC_STAGES(2)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .ext_clk_in(ext), .mon_en_pin(pin),
    .sw_disable(swd), .prescale_mode(pre), .flag_clr(clr),
    .sel_fallback(sel), .fb_div2_en(div), .fail_irq(irq));

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q = '{0, 0, 0}; quiet = 0; m_sel = 0; m_irq = 0; m_mode = 0; m_strap = 0;
    end else begin
      bit moved, hit;
      moved = (q[q.size()-2] != q[q.size()-3]);
      hit = 0;
      if (pin && !swd && !m_sel && !moved) begin
        quiet++;
        if (quiet == T) hit = 1;
      end else quiet = 0;
      if (hit) quiet = 0;
      m_irq = hit ? 1'b1 : (m_irq && !clr);
      m_sel = m_sel || hit;
      if (!m_strap) begin m_strap = 1; m_mode = pre; end
      q.push_back(ext);
      if (q.size() > 3) void'(q.pop_front());
    end
  end

  always @(negedge clk) if (!done) begin
    chk({phase, "/R1 sel"}, sel, m_sel);
    chk({phase, "/R7 div"}, div, m_sel && m_mode);
    chk({phase, "/R3 irq"}, irq, m_irq);
  end

  always @(posedge clk) if (cyc > 20000 && !done) begin
    done = 1; total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic toggle(int half, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % half == 0) ext = ~ext;
    end
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk); rst_n = 0; pre = strap; ext = 0;
    wait_n(3);
    phase = "R10";
    chk("R10 sel", sel, 1'b0); chk("R10 div", div, 1'b0); chk("R10 irq", irq, 1'b0);
    rst_n = 1;
  endtask

  initial begin
    do_reset(1'b0);
    phase = "R2"; toggle(4, 80); toggle(12, 96); toggle(16, 128);
    chk("R2 no switch at 16-cycle spacing", sel, 1'b0);
    phase = "R1"; toggle(17, 40);
    chk("R1 switched at 17-cycle spacing", sel, 1'b1);
    chk("R3 flag raised", irq, 1'b1);
    phase = "R4"; toggle(3, 60); pin = 0; swd = 1; wait_n(5); pin = 1; swd = 0;
    chk("R4 fallback held", sel, 1'b1);
    chk("R8 flag not cleared by recovery", irq, 1'b1);
    phase = "R8"; clr = 1; wait_n(1); clr = 0; wait_n(1);
    chk("R8 flag cleared", irq, 1'b0);
    chk("R4 still fallback after clear", sel, 1'b1);

    do_reset(1'b1);
    chk("R4 reset returns to external", sel, 1'b0);
    phase = "R7"; wait_n(2); pre = 0;
    phase = "R5"; pin = 0; wait_n(60);
    chk("R5 pin low blocks switch", sel, 1'b0);
    pin = 1; wait_n(T + 4);
    chk("R5 switch after enable", sel, 1'b1);
    chk("R7 divide with prescaler strap", div, 1'b1);

    do_reset(1'b0);
    phase = "R6"; swd = 1; wait_n(60);
    chk("R6 software bit blocks switch", sel, 1'b0);
    swd = 0; toggle(5, 30);
    phase = "R9"; clr = 1; wait_n(T + 6); clr = 0;
    chk("R9 switched under constant clear", sel, 1'b1);
    chk("R7 no divide in direct mode", div, 1'b0);
    wait_n(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // R9: on the detection cycle with clear held, flag must read 1
  always @(negedge clk)
    if (!done && phase == "R9" && m_sel && $rose(sel)) chk("R9 set beats clear", irq, 1'b1);
endmodule